// File: doc/BRIEF.md
# NAND Hamming ECC Check-Correct Unit

This block guards one 512-byte chunk of NAND data with a single-error-correcting Hamming code. Bytes arrive as a stream qualified by a valid strobe, with a last strobe marking the final byte. For every accepted byte the unit folds the data into twelve pairs of line parities. Each pair covers one address bit of the 12-bit bit address, which is made of a 9-bit byte index and a 3-bit bit position. The parities are packed into a 24-bit code and presented inverted, so a fully erased chunk produces the same all-ones code that an erased spare area holds.

On the write path the code is taken from `code_o` once `code_ready` is high and then stored as three bytes, least significant byte first. On the read path the chunk is streamed through again and the stored code is presented with a compare strobe. One cycle later the unit reports one of four outcomes:

- the data is clean;
- a single data bit is wrong, reported with its byte index and a one-hot bit mask;
- only the stored code has a flipped bit;
- the error cannot be corrected.

A downstream consumer patches its copy of the data using the reported index and mask.

Top module: `nand_hamming_ecc`

## Requirements
- R1: `code_o` bit k of the low half (bits 11:0) is the inverted XOR of every data bit whose 12-bit address {byte index[8:0], bit position[2:0]} has bit k equal to 0. Bit 12+k is the inverted XOR of the data bits whose address bit k is 1. Stored code byte 0 is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16.
- R2: The code is inverted. An empty accumulator and a chunk of 512 bytes of 0xFF both give `code_o` = 24'hFFFFFF.
- R3: A `start` pulse clears the accumulators, the byte counter and `code_ready`. A byte offered in the same cycle as `start` is dropped.
- R4: Bytes with `in_valid` low are ignored whatever `in_byte` and `in_last` carry. `code_ready` goes high in the cycle after a byte with `in_last` is accepted, and it stays high until the next `start`.
- R5: If the stored code equals `code_o` at the compare strobe, `status` = 0 (clean).
- R6: Let diff = `code_o` XOR `stored_code`. If diff[23:12] XOR diff[11:0] is all ones, `status` = 1 (data fixed), `err_byte` = diff[23:15] and `err_mask` = 1 << diff[14:12].
- R7: A pattern that meets R6 but whose byte index is not below the parameter `CHUNK_BYTES` gives `status` = 3 (uncorrectable).
- R8: A diff with exactly one bit set gives `status` = 2 (code-only error), with `err_byte` = 0 and `err_mask` = 0.
- R9: Any other non-zero diff gives `status` = 3, with `err_byte` and `err_mask` at 0.
- R10: `done` is high for exactly the one cycle after `cmp_valid`. `status`, `err_byte` and `err_mask` hold their values until the next compare, and they are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears the accumulation for a new chunk |
| in_valid | input | 1 | Data byte qualifier |
| in_byte | input | 8 | Data byte |
| in_last | input | 1 | Marks the final byte of the chunk |
| code_o | output | 24 | Inverted packed parity code |
| code_ready | output | 1 | A full chunk has been accumulated |
| cmp_valid | input | 1 | Compare strobe |
| stored_code | input | 24 | Code read back from spare storage |
| done | output | 1 | Result valid pulse |
| status | output | 2 | 0 clean, 1 data fixed, 2 code-only, 3 uncorrectable |
| err_byte | output | 9 | Index of the byte to patch |
| err_mask | output | 8 | XOR mask for that byte |

## Verification
The code generator is driven with three kinds of chunk:

- an erased chunk, which pins down the inversion;
- a chunk whose bytes follow an arithmetic pattern with idle cycles carrying garbage, which checks the line and column parity placement and the valid qualifier;
- a cleared accumulator with a byte offered alongside `start`.

The checker is then walked through a table of diff patterns: zero, data-bit errors at the first, last and middle addresses, single-bit code errors at both ends of the code, and multi-bit patterns. Together these separate all four outcomes and fix the index and mask arithmetic.

Two further directed cases complete the coverage. A re-read chunk with one real flipped data bit checks the correction end to end. A second instance with a shorter chunk shows that an out-of-range index becomes uncorrectable where the full-size instance corrects it.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int COL_BITS  = 3;
  localparam int LINE_BITS = 9;
  localparam int BYTE_W    = 1 << COL_BITS;
  localparam int ADDR_BITS = COL_BITS + LINE_BITS;
  localparam int CODE_W    = 2 * ADDR_BITS;

  typedef enum logic [1:0] {
    ECC_CLEAN      = 2'd0,
    ECC_DATA_FIXED = 2'd1,
    ECC_CODE_FIXED = 2'd2,
    ECC_FATAL      = 2'd3
  } ecc_status_e;

  // Bits of a byte whose in-byte position has address bit k set
  function automatic logic [BYTE_W-1:0] col_mask(input int k);
    logic [BYTE_W-1:0] m;
    for (int p = 0; p < BYTE_W; p++) m[p] = ((p >> k) & 1) == 1;
    return m;
  endfunction
endpackage

// File: rtl/nand_hamming_accum.sv
module nand_hamming_accum
  import nand_ecc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 take,
  input  logic [BYTE_W-1:0]    byte_in,
  input  logic                 last_in,
  output logic [ADDR_BITS-1:0] even_par,
  output logic [ADDR_BITS-1:0] odd_par,
  output logic                 ready
);
  logic [LINE_BITS-1:0] line_q;
  logic [ADDR_BITS-1:0] even_q, odd_q, even_d, odd_d;
  logic                 ready_q;
  logic                 byte_x;

  assign byte_x = ^byte_in;

  // Column parities: depend on the bit position inside the byte
  for (genvar k = 0; k < COL_BITS; k++) begin : g_col
    localparam logic [BYTE_W-1:0] M = col_mask(k);
    assign odd_d[k]  = odd_q[k]  ^ (^(byte_in & M));
    assign even_d[k] = even_q[k] ^ (^(byte_in & ~M));
  end

  // Line parities: depend on the byte index within the chunk
  for (genvar k = COL_BITS; k < ADDR_BITS; k++) begin : g_line
    assign odd_d[k]  = odd_q[k]  ^ (line_q[k-COL_BITS] & byte_x);
    assign even_d[k] = even_q[k] ^ (~line_q[k-COL_BITS] & byte_x);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      line_q  <= '0;
      even_q  <= '0;
      odd_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (take) begin
        even_q <= even_d;
        odd_q  <= odd_d;
        line_q <= line_q + 1'b1;
      end
      ready_q <= ready_q | (take & last_in);
    end
  end

  assign even_par = even_q;
  assign odd_par  = odd_q;
  assign ready    = ready_q;

  p_ready_after_last_r4: assert property (@(posedge clk) disable iff (rst)
    (take && last_in && !clear) |=> ready);
endmodule

// File: rtl/nand_hamming_judge.sv
module nand_hamming_judge
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic [CODE_W-1:0]    diff,
  output ecc_status_e          status,
  output logic [LINE_BITS-1:0] byte_idx,
  output logic [BYTE_W-1:0]    bit_mask
);
  localparam logic [LINE_BITS:0] LIMIT = (LINE_BITS+1)'(CHUNK_BYTES);

  logic [ADDR_BITS-1:0] lo_h, hi_h;
  logic                 is_pair, is_single, in_range;

  assign lo_h      = diff[ADDR_BITS-1:0];
  assign hi_h      = diff[CODE_W-1:ADDR_BITS];
  assign is_pair   = (hi_h ^ lo_h) == '1;
  assign is_single = (diff & (diff - 1'b1)) == '0;
  assign in_range  = {1'b0, hi_h[ADDR_BITS-1:COL_BITS]} < LIMIT;

  always_comb begin
    status   = ECC_FATAL;
    byte_idx = '0;
    bit_mask = '0;
    if (diff == '0) begin
      status = ECC_CLEAN;
    end else if (is_pair) begin
      if (in_range) begin
        status   = ECC_DATA_FIXED;
        byte_idx = hi_h[ADDR_BITS-1:COL_BITS];
        bit_mask = BYTE_W'(1) << hi_h[COL_BITS-1:0];
      end
    end else if (is_single) begin
      status = ECC_CODE_FIXED;
    end
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 in_valid,
  input  logic [BYTE_W-1:0]    in_byte,
  input  logic                 in_last,
  output logic [CODE_W-1:0]    code_o,
  output logic                 code_ready,
  input  logic                 cmp_valid,
  input  logic [CODE_W-1:0]    stored_code,
  output logic                 done,
  output logic [1:0]           status,
  output logic [LINE_BITS-1:0] err_byte,
  output logic [BYTE_W-1:0]    err_mask
);
  localparam logic [LINE_BITS:0] LIMIT = (LINE_BITS+1)'(CHUNK_BYTES);

  logic [ADDR_BITS-1:0] even_par, odd_par;
  logic [CODE_W-1:0]    diff;
  ecc_status_e          j_status;
  logic [LINE_BITS-1:0] j_byte;
  logic [BYTE_W-1:0]    j_mask;

  logic                 done_q;
  ecc_status_e          status_q;
  logic [LINE_BITS-1:0] byte_q;
  logic [BYTE_W-1:0]    mask_q;

  nand_hamming_accum u_accum (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .take     (in_valid),
    .byte_in  (in_byte),
    .last_in  (in_last),
    .even_par (even_par),
    .odd_par  (odd_par),
    .ready    (code_ready)
  );

  assign code_o = ~{odd_par, even_par};
  assign diff   = code_o ^ stored_code;

  nand_hamming_judge #(.CHUNK_BYTES(CHUNK_BYTES)) u_judge (
    .diff     (diff),
    .status   (j_status),
    .byte_idx (j_byte),
    .bit_mask (j_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      status_q <= ECC_CLEAN;
      byte_q   <= '0;
      mask_q   <= '0;
    end else begin
      done_q <= cmp_valid;
      if (cmp_valid) begin
        status_q <= j_status;
        byte_q   <= j_byte;
        mask_q   <= j_mask;
      end
    end
  end

  assign done     = done_q;
  assign status   = status_q;
  assign err_byte = byte_q;
  assign err_mask = mask_q;

  p_start_clears_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (code_o == '1 && !code_ready));
  p_match_clean_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && stored_code == code_o) |=> (status == 2'd0));
  p_fix_mask_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd1) |-> ($countones(err_mask) == 1));
  p_fix_index_range_r7: assert property (@(posedge clk) disable iff (rst)
    (done && status == 2'd1) |-> ({1'b0, err_byte} < LIMIT));
  p_code_only_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && $countones(stored_code ^ code_o) == 1) |=>
      (status == 2'd2 && err_mask == '0));
  p_done_follows_cmp_r10: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> done);
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> !done);
endmodule

// File: tb/sim_nand_hamming_ecc.sv
`timescale 1ns/1ps
module sim_nand_hamming_ecc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_last = 1'b0;
  logic        cmp_valid = 1'b0;
  logic [23:0] stored_code = 24'h0;

  logic [23:0] code0, code1;
  logic        rdy0, rdy1, done0, done1;
  logic [1:0]  st0, st1;
  logic [8:0]  eb0, eb1;
  logic [7:0]  em0, em1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mem [512];

  always #4 clk = ~clk;

  nand_hamming_ecc u0 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .code_o(code0), .code_ready(rdy0), .cmp_valid(cmp_valid),
    .stored_code(stored_code), .done(done0), .status(st0), .err_byte(eb0), .err_mask(em0));

  nand_hamming_ecc #(.CHUNK_BYTES(300)) u1 (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .code_o(code1), .code_ready(rdy1), .cmp_valid(cmp_valid),
    .stored_code(stored_code), .done(done1), .status(st1), .err_byte(eb1), .err_mask(em1));

  // diff, status, byte, mask
  localparam logic [42:0] VEC [9] = '{
    {24'h000000, 2'd0, 9'd0,   8'h00},
    {24'h000FFF, 2'd1, 9'd0,   8'h01},
    {24'hFFF000, 2'd1, 9'd511, 8'h80},
    {24'h52BAD4, 2'd1, 9'd165, 8'h08},
    {24'h010FEF, 2'd1, 9'd2,   8'h01},
    {24'h000001, 2'd2, 9'd0,   8'h00},
    {24'h800000, 2'd2, 9'd0,   8'h00},
    {24'h000003, 2'd3, 9'd0,   8'h00},
    {24'hFFFFFF, 2'd3, 9'd0,   8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model_code();
    logic [11:0] hi = '0;
    logic [11:0] lo = '0;
    for (int i = 0; i < 512; i++)
      for (int p = 0; p < 8; p++)
        if (mem[i][p]) begin
          hi ^= {i[8:0], p[2:0]};
          lo ^= ~{i[8:0], p[2:0]};
        end
    return ~{hi, lo};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic stream(input bit gaps);
    for (int i = 0; i < 512; i++) begin
      if (gaps && (i % 7) == 3) begin
        @(negedge clk);
        in_valid = 1'b0; in_byte = 8'h5A; in_last = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b1; in_byte = mem[i]; in_last = (i == 511);
    end
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
  endtask

  task automatic compare(input logic [23:0] s);
    @(negedge clk); cmp_valid = 1'b1; stored_code = s;
    @(negedge clk); cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] ref_code;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(code0 == 24'hFFFFFF, "R2 reset code", code0, 24'hFFFFFF);
    chk(!rdy0, "R4 reset ready", rdy0, 0);
    chk(!done0 && st0 == 0 && em0 == 0, "R10 reset result", {done0, st0, em0}, 0);

    // Erased chunk
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    pulse_start();
    stream(1'b0);
    chk(code0 == 24'hFFFFFF, "R2 erased chunk", code0, 24'hFFFFFF);
    chk(rdy0, "R4 ready after last", rdy0, 1);

    // Patterned chunk with idle garbage cycles
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    pulse_start();
    chk(!rdy0, "R3 start clears ready", rdy0, 0);
    stream(1'b1);
    ref_code = model_code();
    chk(code0 == ref_code, "R1 pattern code", code0, ref_code);
    chk(rdy0, "R4 ready with gaps", rdy0, 1);

    // Table of diff patterns
    for (int n = 0; n < 9; n++) begin
      compare(ref_code ^ VEC[n][42:19]);
      chk(done0, "R10 done pulse", done0, 1);
      chk(st0 == VEC[n][18:17], $sformatf("R5 R6 R8 R9 status vec%0d", n), st0, VEC[n][18:17]);
      chk(eb0 == VEC[n][16:8], $sformatf("R6 byte vec%0d", n), eb0, VEC[n][16:8]);
      chk(em0 == VEC[n][7:0], $sformatf("R6 mask vec%0d", n), em0, VEC[n][7:0]);
      @(negedge clk);
      chk(!done0, "R10 done single cycle", done0, 0);
      chk(st0 == VEC[n][18:17], "R10 status held", st0, VEC[n][18:17]);
    end

    // Out-of-range index: byte 400 bit 2
    compare(ref_code ^ 24'hC8237D);
    chk(st0 == 2'd1 && eb0 == 9'd400 && em0 == 8'h04, "R6 byte 400 full chunk",
        {st0, eb0, em0}, {2'd1, 9'd400, 8'h04});
    chk(st1 == 2'd3, "R7 index beyond chunk", st1, 3);

    // Real data flip on re-read
    mem[200] = mem[200] ^ 8'h10;
    pulse_start();
    stream(1'b0);
    compare(ref_code);
    chk(st0 == 2'd1 && eb0 == 9'd200 && em0 == 8'h10, "R6 flipped data bit",
        {st0, eb0, em0}, {2'd1, 9'd200, 8'h10});

    // Byte offered together with start is dropped
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_byte = 8'h81; in_last = 1'b1;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
    @(negedge clk);
    chk(code0 == 24'hFFFFFF, "R3 byte with start dropped", code0, 24'hFFFFFF);
    chk(!rdy0, "R3 last with start dropped", rdy0, 0);

    // Valid-low garbage has no effect
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'hE7; in_last = 1'b1;
    @(negedge clk);
    in_byte = 8'h00; in_last = 1'b0;
    @(negedge clk);
    chk(code0 == 24'hFFFFFF && !rdy0, "R4 invalid byte ignored", {rdy0, code0}, 25'h0FFFFFF);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule